// File: doc/BRIEF.md
# Multi-Policy Register Field

This block is one software-visible field of a control or status register. A single parameter selects its access policy from a set of twenty-five. The policy decides what a bus write does, whether a bus read has a side effect, whether a read is an error, and which hardware events may change the stored bits. Address decoding and packing several fields into one register word are done by the surrounding register file. That logic drives one write strobe and one read strobe per field and collects the read data and the error flag.

The bus side sees a write strobe with write data, and a read strobe with read data and an error flag that answer combinationally in the same cycle. The hardware side supplies a live value for read-only status fields and per-bit set and clear event vectors. It observes the stored value continuously. An asynchronous active-low hard reset restores the reset value and re-arms the write-once policies. A synchronous soft reset restores the reset value but leaves write-once state alone.

Top module: `field_reg`

## Requirements
- R1: After hard reset every stored policy shows RESET_VAL on fld_q and rd_data. The RO policy always shows hw_val on fld_q and rd_data, whatever the bus does.
- R2: rd_data during a read cycle is the value held before that read. For RC, WRC, WSRC, W1SRC and W0SRC, a read makes all bits 0 from the next clock edge. A read effect overrides a write in the same cycle.
- R3: For RS, WRS, WCRS, W1CRS and W0CRS, a read makes all bits 1 from the next clock edge. rd_data still returns the old value.
- R4: For WO, WOC, WOS and WO1, rd_err is 1 in any cycle with rd_en = 1, and rd_data is all zeros. For every other policy rd_err stays 0 and a read returns the value.
- R5: RW, WRC, WRS and WO store wr_data. WC, WCRS and WOC make all bits 0 on a write. WS, WSRC and WOS make all bits 1 on a write. RO, RC and RS ignore writes.
- R6: W1C and W1CRS clear, W1S and W1SRC set, and W1T inverts each field bit whose wr_data bit is 1. Bits written as 0 are unchanged.
- R7: W0C and W0CRS clear, W0S and W0SRC set, and W0T inverts each field bit whose wr_data bit is 0. Bits written as 1 are unchanged.
- R8: W1 and WO1 store the first write after hard reset. Every later write is ignored until the next hard reset.
- R9: For RC, WC, W1C, W0C and WOC, a 1 in hw_set makes that field bit 1 at the next edge. The other policies ignore hw_set.
- R10: For RS, WS, W1S, W0S and WOS, a 1 in hw_clr makes that field bit 0 at the next edge. The other policies ignore hw_clr.
- R11: When a hardware set or clear event and a bus write or read effect touch the same bit in one cycle, the hardware event decides that bit.
- R12: srst = 1 at a clock edge loads RESET_VAL, overriding writes, reads and events. It does not re-arm W1 or WO1, and a write in the soft-reset cycle does not use up the write-once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| hrst_n | input | 1 | Asynchronous hard reset, active low |
| srst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Bus write strobe |
| wr_data | input | WIDTH | Bus write data |
| rd_en | input | 1 | Bus read strobe |
| rd_data | output | WIDTH | Read data (pre-read value) |
| rd_err | output | 1 | Read of a write-only policy |
| hw_val | input | WIDTH | Live value for the RO policy |
| hw_set | input | WIDTH | Per-bit hardware set events |
| hw_clr | input | WIDTH | Per-bit hardware clear events |
| fld_q | output | WIDTH | Current field value |

## Verification
The cycle that matters is the one where a bus access and a hardware event hit the same bit. One example is a write-1-to-clear write arriving with a set event. Another is a clear-on-read read arriving with a set event. A third is a set-all write arriving with a clear event. The bench provokes each by raising the write or read strobe and the event vector in one cycle. It runs every policy in parallel and judges each field value one edge later against a reference model in which the event decides the bit. The soft reset is also raised together with a write to W1/WO1, to show that it wins and does not consume the write-once.

// File: rtl/field_pkg.sv
package field_pkg;

   typedef enum logic [4:0] {
      ACC_RO, ACC_RW, ACC_RC, ACC_RS, ACC_WRC, ACC_WRS, ACC_WC, ACC_WS,
      ACC_WSRC, ACC_WCRS, ACC_W1C, ACC_W1S, ACC_W1T, ACC_W0C, ACC_W0S,
      ACC_W0T, ACC_W1SRC, ACC_W1CRS, ACC_W0SRC, ACC_W0CRS, ACC_WO,
      ACC_WOC, ACC_WOS, ACC_W1, ACC_WO1
   } acc_e;

   localparam int ACC_COUNT = 25;

   typedef enum logic [3:0] {
      WK_NONE, WK_STORE, WK_CLRALL, WK_SETALL, WK_B1C, WK_B1S, WK_B1T,
      WK_B0C, WK_B0S, WK_B0T, WK_ONCE
   } wkind_e;

   typedef enum logic [1:0] {RK_KEEP, RK_CLR, RK_SET} rkind_e;

   function automatic wkind_e wr_kind(acc_e a);
      case (a)
         ACC_RW, ACC_WRC, ACC_WRS, ACC_WO:     return WK_STORE;
         ACC_WC, ACC_WCRS, ACC_WOC:            return WK_CLRALL;
         ACC_WS, ACC_WSRC, ACC_WOS:            return WK_SETALL;
         ACC_W1C, ACC_W1CRS:                   return WK_B1C;
         ACC_W1S, ACC_W1SRC:                   return WK_B1S;
         ACC_W1T:                              return WK_B1T;
         ACC_W0C, ACC_W0CRS:                   return WK_B0C;
         ACC_W0S, ACC_W0SRC:                   return WK_B0S;
         ACC_W0T:                              return WK_B0T;
         ACC_W1, ACC_WO1:                      return WK_ONCE;
         default:                              return WK_NONE;
      endcase
   endfunction

   function automatic rkind_e rd_kind(acc_e a);
      case (a)
         ACC_RC, ACC_WRC, ACC_WSRC, ACC_W1SRC, ACC_W0SRC: return RK_CLR;
         ACC_RS, ACC_WRS, ACC_WCRS, ACC_W1CRS, ACC_W0CRS: return RK_SET;
         default:                                         return RK_KEEP;
      endcase
   endfunction

   function automatic logic is_wonly(acc_e a);
      return (a == ACC_WO) || (a == ACC_WOC) || (a == ACC_WOS) || (a == ACC_WO1);
   endfunction

   function automatic logic takes_hw_set(acc_e a);
      return (a == ACC_RC) || (a == ACC_WC) || (a == ACC_W1C) ||
             (a == ACC_W0C) || (a == ACC_WOC);
   endfunction

   function automatic logic takes_hw_clr(acc_e a);
      return (a == ACC_RS) || (a == ACC_WS) || (a == ACC_W1S) ||
             (a == ACC_W0S) || (a == ACC_WOS);
   endfunction

endpackage

// File: rtl/field_wr_eff.sv
module field_wr_eff
   import field_pkg::*;
#(
   parameter int     WIDTH = 8,
   parameter wkind_e KIND  = WK_STORE
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] wd,
   input  logic             we,
   input  logic             once_open,
   output logic [WIDTH-1:0] nxt
);

   always_comb begin
      nxt = cur;
      if (we) begin
         case (KIND)
            WK_STORE:  nxt = wd;
            WK_CLRALL: nxt = '0;
            WK_SETALL: nxt = '1;
            WK_B1C:    nxt = cur & ~wd;
            WK_B1S:    nxt = cur | wd;
            WK_B1T:    nxt = cur ^ wd;
            WK_B0C:    nxt = cur & wd;
            WK_B0S:    nxt = cur | ~wd;
            WK_B0T:    nxt = cur ^ ~wd;
            WK_ONCE:   nxt = once_open ? wd : cur;
            default:   nxt = cur;
         endcase
      end
   end

endmodule

// File: rtl/field_rd_eff.sv
module field_rd_eff
   import field_pkg::*;
#(
   parameter int     WIDTH = 8,
   parameter rkind_e KIND  = RK_KEEP
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             re,
   output logic [WIDTH-1:0] nxt
);

   always_comb begin
      nxt = cur;
      if (re) begin
         case (KIND)
            RK_CLR:  nxt = '0;
            RK_SET:  nxt = '1;
            default: nxt = cur;
         endcase
      end
   end

endmodule

// File: rtl/field_once.sv
module field_once (
   input  logic clk,
   input  logic hrst_n,
   input  logic take,
   output logic open
);

   logic used_q;

   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n)   used_q <= 1'b0;
      else if (take) used_q <= 1'b1;
   end

   assign open = ~used_q;

endmodule

// File: rtl/field_reg.sv
module field_reg
   import field_pkg::*;
#(
   parameter int               WIDTH     = 8,
   parameter acc_e             ACC       = ACC_RW,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             hrst_n,
   input  logic             srst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_err,
   input  logic [WIDTH-1:0] hw_val,
   input  logic [WIDTH-1:0] hw_set,
   input  logic [WIDTH-1:0] hw_clr,
   output logic [WIDTH-1:0] fld_q
);

   localparam wkind_e WKIND   = wr_kind(ACC);
   localparam rkind_e RKIND   = rd_kind(ACC);
   localparam logic   WONLY   = is_wonly(ACC);
   localparam logic   HWSET   = takes_hw_set(ACC);
   localparam logic   HWCLR   = takes_hw_clr(ACC);
   localparam logic   LIVE_RO = (ACC == ACC_RO);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("field_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] after_wr;
   logic [WIDTH-1:0] after_rd;
   logic [WIDTH-1:0] set_eff;
   logic [WIDTH-1:0] clr_eff;
   logic [WIDTH-1:0] nxt;
   logic             once_open;

   generate
      if (WKIND == WK_ONCE) begin : g_once
         field_once u_once (
            .clk    (clk),
            .hrst_n (hrst_n),
            .take   (wr_en & ~srst),
            .open   (once_open)
         );
      end else begin : g_no_once
         assign once_open = 1'b0;
      end
   endgenerate

   field_wr_eff #(.WIDTH(WIDTH), .KIND(WKIND)) u_wr (
      .cur       (q),
      .wd        (wr_data),
      .we        (wr_en),
      .once_open (once_open),
      .nxt       (after_wr)
   );

   field_rd_eff #(.WIDTH(WIDTH), .KIND(RKIND)) u_rd (
      .cur (after_wr),
      .re  (rd_en),
      .nxt (after_rd)
   );

   assign set_eff = HWSET ? hw_set : '0;
   assign clr_eff = HWCLR ? hw_clr : '0;

   always_comb begin
      if (srst) nxt = RESET_VAL;
      else      nxt = (after_rd | set_eff) & ~clr_eff;
   end

   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) q <= RESET_VAL;
      else         q <= nxt;
   end

   assign fld_q   = LIVE_RO ? hw_val : q;
   assign rd_data = WONLY ? '0 : fld_q;
   assign rd_err  = WONLY & rd_en;

endmodule

// File: rtl/field_reg_chk.sv
module field_reg_chk
   import field_pkg::*;
#(
   parameter int               WIDTH     = 8,
   parameter acc_e             ACC       = ACC_RW,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input logic             clk,
   input logic             hrst_n,
   input logic             srst,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic             rd_en,
   input logic [WIDTH-1:0] rd_data,
   input logic             rd_err,
   input logic [WIDTH-1:0] hw_set,
   input logic [WIDTH-1:0] hw_clr,
   input logic [WIDTH-1:0] fld_q
);

   localparam logic RDCLR  = (rd_kind(ACC) == RK_CLR);
   localparam logic RDSET  = (rd_kind(ACC) == RK_SET);
   localparam logic STORES = (wr_kind(ACC) == WK_STORE);
   localparam logic HWSET  = takes_hw_set(ACC);
   localparam logic HWCLR  = takes_hw_clr(ACC);
   localparam logic LIVE   = (ACC == ACC_RO);

   AST_ERR_NEEDS_READ: assert property (@(posedge clk) disable iff (!hrst_n)
      rd_err |-> rd_en);                                                   // R4
   AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!hrst_n)
      rd_err |-> (rd_data == '0));                                         // R4
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!hrst_n)
      (RDCLR && rd_en && !srst && (hw_set == '0)) |=> (fld_q == '0));      // R2
   AST_READ_SETS: assert property (@(posedge clk) disable iff (!hrst_n)
      (RDSET && rd_en && !srst && (hw_clr == '0)) |=> (fld_q == '1));      // R3
   AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!hrst_n)
      (STORES && wr_en && !rd_en && !srst) |=> (fld_q == $past(wr_data))); // R5
   AST_HWSET_WINS: assert property (@(posedge clk) disable iff (!hrst_n)
      (HWSET && !srst) |=> ((fld_q & $past(hw_set)) == $past(hw_set)));    // R11
   AST_HWCLR_WINS: assert property (@(posedge clk) disable iff (!hrst_n)
      (HWCLR && !srst) |=> ((fld_q & $past(hw_clr)) == '0));               // R11
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!hrst_n)
      (!LIVE && srst) |=> (fld_q == RESET_VAL));                           // R12

endmodule

bind field_reg field_reg_chk #(
   .WIDTH(WIDTH), .ACC(ACC), .RESET_VAL(RESET_VAL)
) u_chk (
   .clk(clk), .hrst_n(hrst_n), .srst(srst), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .hw_set(hw_set),
   .hw_clr(hw_clr), .fld_q(fld_q)
);

// File: tb/field_reg_test.sv
`timescale 1ns/1ps
module field_reg_test;
   import field_pkg::*;

   localparam int         NPOL = ACC_COUNT;
   localparam logic [7:0] RV   = 8'hA5;

   logic       clk = 1'b0;
   logic       hrst_n = 1'b0;
   logic       srst = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0, hw_val = '0, hw_set = '0, hw_clr = '0;
   logic [7:0] q_arr  [NPOL];
   logic [7:0] rd_arr [NPOL];
   logic       err_arr[NPOL];

   logic [7:0] exp_v [NPOL];
   bit         used  [NPOL];
   int         n_chk = 0, n_bad = 0;
   bit         done = 0;

   always #5 clk = ~clk;

   for (genvar g = 0; g < NPOL; g++) begin : g_pol
      field_reg #(.WIDTH(8), .ACC(acc_e'(g)), .RESET_VAL(RV)) uut (
         .clk(clk), .hrst_n(hrst_n), .srst(srst), .wr_en(wr_en),
         .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_arr[g]),
         .rd_err(err_arr[g]), .hw_val(hw_val), .hw_set(hw_set),
         .hw_clr(hw_clr), .fld_q(q_arr[g])
      );
   end

   function automatic bit in_set(acc_e p, string names);
      string s = p.name();
      s = s.substr(4, s.len() - 1);
      names = {" ", names, " "};
      for (int k = 0; k + s.len() + 1 < names.len(); k++)
         if (names.substr(k, k + s.len() + 1) == {" ", s, " "}) return 1;
      return 0;
   endfunction

   function automatic logic [7:0] model(acc_e p, logic [7:0] v, bit we,
      logic [7:0] wd, bit re, logic [7:0] hs, logic [7:0] hc, bit open, bit sr);
      if (sr) return RV;
      if (we) begin
         if (in_set(p, "RW WRC WRS WO"))       v = wd;
         else if (in_set(p, "WC WCRS WOC"))    v = 8'h00;
         else if (in_set(p, "WS WSRC WOS"))    v = 8'hFF;
         else if (in_set(p, "W1C W1CRS"))      v = v & ~wd;
         else if (in_set(p, "W1S W1SRC"))      v = v | wd;
         else if (in_set(p, "W1T"))            v = v ^ wd;
         else if (in_set(p, "W0C W0CRS"))      v = v & wd;
         else if (in_set(p, "W0S W0SRC"))      v = v | ~wd;
         else if (in_set(p, "W0T"))            v = v ^ ~wd;
         else if (in_set(p, "W1 WO1") && open) v = wd;
      end
      if (re) begin
         if (in_set(p, "RC WRC WSRC W1SRC W0SRC"))      v = 8'h00;
         else if (in_set(p, "RS WRS WCRS W1CRS W0CRS")) v = 8'hFF;
      end
      if (in_set(p, "RC WC W1C W0C WOC")) v = v | hs;
      if (in_set(p, "RS WS W1S W0S WOS")) v = v & ~hc;
      return v;
   endfunction

   task automatic chk(string req, string what, int i, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s policy %s: actual %h expected %h", req, what,
                  acc_e'(i), act, exp);
      end
   endtask

   // One bus/hardware cycle applied to every policy at once.
   task automatic step(string req, bit we, logic [7:0] wd, bit re,
                       logic [7:0] hs, logic [7:0] hc, logic [7:0] hv, bit sr);
      logic [7:0] nx [NPOL];
      @(negedge clk);
      wr_en = we; wr_data = wd; rd_en = re; hw_set = hs; hw_clr = hc;
      hw_val = hv; srst = sr;
      #1;
      for (int i = 0; i < NPOL; i++) begin
         acc_e p   = acc_e'(i);
         bit   wo  = in_set(p, "WO WOC WOS WO1");
         logic [7:0] cur = (p == ACC_RO) ? hv : exp_v[i];
         if (re) begin
            chk(wo ? "R4" : req, "rd_err", i, {7'b0, err_arr[i]}, {7'b0, wo});
            chk(wo ? "R4" : req, "rd_data", i, rd_arr[i], wo ? 8'h00 : cur);
         end
         nx[i] = model(p, exp_v[i], we, wd, re, hs, hc, !used[i], sr);
         if (we && !sr && in_set(p, "W1 WO1")) used[i] = 1;
      end
      @(posedge clk);
      #1;
      for (int i = 0; i < NPOL; i++) begin
         exp_v[i] = nx[i];
         chk(req, "fld_q", i, q_arr[i], (acc_e'(i) == ACC_RO) ? hv : nx[i]);
      end
      wr_en = 0; rd_en = 0; hw_set = '0; hw_clr = '0; srst = 0;
   endtask

   task automatic hard_reset();
      @(negedge clk);
      hrst_n = 0;
      for (int i = 0; i < NPOL; i++) begin exp_v[i] = RV; used[i] = 0; end
      @(negedge clk);
      hrst_n = 1;
   endtask

   task automatic t_reset();   // R1
      hard_reset();
      #1;
      for (int i = 0; i < NPOL; i++)
         chk("R1", "reset fld_q", i, q_arr[i], (acc_e'(i) == ACC_RO) ? hw_val : RV);
      step("R1", 1, 8'h3C, 1, 0, 0, 8'h96, 0);
   endtask

   task automatic t_read_clear();   // R2
      step("R2", 1, 8'h7E, 0, 0, 0, 8'h11, 0);
      step("R2", 0, 0, 1, 0, 0, 8'h22, 0);
      step("R2", 1, 8'hC3, 1, 0, 0, 8'h33, 0);
   endtask

   task automatic t_read_set();   // R3
      step("R3", 1, 8'h00, 0, 0, 0, 8'h44, 0);
      step("R3", 0, 0, 1, 0, 0, 8'h55, 0);
      step("R3", 0, 0, 1, 0, 0, 8'h66, 0);
   endtask

   task automatic t_wo_err();   // R4
      step("R4", 0, 0, 1, 0, 0, 8'h01, 0);
      step("R4", 1, 8'h5A, 1, 0, 0, 8'h02, 0);
   endtask

   task automatic t_plain_write();   // R5
      step("R5", 1, 8'h81, 0, 0, 0, 8'h03, 0);
      step("R5", 1, 8'h18, 0, 0, 0, 8'h04, 0);
   endtask

   task automatic t_bit_one();   // R6
      step("R6", 1, 8'hFF, 0, 0, 0, 8'h05, 0);
      step("R6", 1, 8'h0F, 0, 0, 0, 8'h06, 0);
      step("R6", 1, 8'h33, 0, 0, 0, 8'h07, 0);
   endtask

   task automatic t_bit_zero();   // R7
      step("R7", 1, 8'h00, 0, 0, 0, 8'h08, 0);
      step("R7", 1, 8'hF0, 0, 0, 0, 8'h09, 0);
      step("R7", 1, 8'hCC, 0, 0, 0, 8'h0A, 0);
   endtask

   task automatic t_once();   // R8
      hard_reset();
      step("R8", 1, 8'h3E, 0, 0, 0, 8'h0B, 0);
      step("R8", 1, 8'hC1, 0, 0, 0, 8'h0C, 0);
      hard_reset();
      step("R8", 1, 8'h77, 0, 0, 0, 8'h0D, 0);
   endtask

   task automatic t_hw_set();   // R9
      step("R9", 1, 8'h00, 0, 0, 0, 8'h0E, 0);
      step("R9", 0, 0, 0, 8'h12, 0, 8'h0F, 0);
      step("R9", 0, 0, 0, 8'h80, 0, 8'h10, 0);
   endtask

   task automatic t_hw_clr();   // R10
      step("R10", 1, 8'hFF, 0, 0, 0, 8'h11, 0);
      step("R10", 0, 0, 0, 0, 8'h21, 8'h12, 0);
      step("R10", 0, 0, 0, 0, 8'h0C, 8'h13, 0);
   endtask

   task automatic t_collide();   // R11
      step("R11", 1, 8'hFF, 0, 8'h0F, 8'hF0, 8'h14, 0);
      step("R11", 1, 8'h00, 1, 8'h3C, 8'h3C, 8'h15, 0);
      step("R11", 0, 0, 1, 8'hA0, 8'h05, 8'h16, 0);
   endtask

   task automatic t_soft();   // R12
      hard_reset();
      step("R12", 1, 8'h42, 0, 0, 0, 8'h17, 1);
      step("R12", 1, 8'h24, 0, 0, 0, 8'h18, 0);
      step("R12", 1, 8'h99, 1, 8'hFF, 8'hFF, 8'h19, 1);
      step("R12", 1, 8'h66, 0, 0, 0, 8'h1A, 0);
   endtask

   initial begin
      for (int i = 0; i < NPOL; i++) begin exp_v[i] = RV; used[i] = 0; end
      repeat (3) @(negedge clk);
      hrst_n = 1;
      t_reset();
      t_read_clear();
      t_read_set();
      t_wo_err();
      t_plain_write();
      t_bit_one();
      t_bit_zero();
      t_once();
      t_hw_set();
      t_hw_clr();
      t_collide();
      t_soft();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule